// File: doc/BRIEF.md
# Alias-Aware Virtually Indexed Tag Lookup

This block is the tag-lookup stage of a 32 KB, 2-way set-associative data cache whose set index is taken from address bits [13:6]. The two top index bits, [13:12], sit above the 4 KB untranslated page offset. While translation is still in flight the physical value of those two bits is unknown. A line for the requested physical address may therefore live in any of four sets that share the low six index bits. The block holds the tags together with a valid and a dirty flag for every line. Each stored tag is the full physical frame, address bits [31:12], including the two bits that also pick the set.

A lookup runs in two cycles. In the first cycle the virtual index is presented, and the tags and state of all four candidate sets (eight lines) are read and registered. In the second cycle the physical frame from translation arrives, and the eight tags are compared with it at the same time. A match in the set named by the virtual index is a hit. A match in any of the other three sets is an alias: the block reports where that line sits and whether it is dirty, then clears it, so that the refill path can write it back and bring it into the indexed set. With no match the result is a plain miss.

A separate fill port installs a clean, valid tag into a chosen way of a chosen set. A write lookup that hits marks the line dirty.

Top module: `alias_tag_lookup`

## Requirements
- R1: After reset every line is invalid: res_valid is low and any lookup reports a miss.
- R2: A lookup presented on lk_vidx with lk_valid high is answered in the next cycle. During that cycle res_valid is high, and the outcome depends on the xl_frame value driven in that same cycle. In a cycle that follows no lookup, res_valid is low.
- R3: A valid line in the set named by lk_vidx whose 20-bit tag equals xl_frame gives res_hit, with res_way naming that way (0 or 1).
- R4: All 20 frame bits take part in the compare. A frame that differs from a stored tag in any single bit, including bit 0 (address bit 12), does not match it.
- R5: If there is no hit, and a valid line in one of the other three candidate sets matches, the result is res_alias and not res_hit. res_alias_set is that line's 8-bit set index (bits [7:6] differ from lk_vidx[7:6], bits [5:0] equal lk_vidx[5:0]) and res_way is its way.
- R6: res_writeback is high together with res_alias exactly when the aliased line is dirty. It is never high without res_alias.
- R7: The line reported by an alias is invalid from the following cycle on.
- R8: A lookup with lk_write high that hits sets the dirty flag of the line it hit.
- R9: A fill writes fill_tag into way fill_way of set fill_set, marks the line valid and clears its dirty flag, even if the line was dirty before.
- R10: A lookup whose first cycle coincides with the second cycle of an earlier lookup sees the invalidation or dirty marking made by that earlier lookup.
- R11: If a fill and an alias invalidation target the same line in the same cycle, the fill wins: the line holds the filled tag, valid and clean.
- R12: A write lookup that misses, or that only aliases, marks no line dirty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Start a lookup this cycle |
| lk_vidx | input | 8 | Virtual set index, address bits [13:6] |
| lk_write | input | 1 | The lookup is a store; a hit marks the line dirty |
| xl_frame | input | 20 | Translated frame, physical bits [31:12], driven in the second cycle |
| fill_en | input | 1 | Install a tag |
| fill_set | input | 8 | Set that receives the fill |
| fill_way | input | 1 | Way that receives the fill |
| fill_tag | input | 20 | Frame tag to install |
| res_valid | output | 1 | A result is presented this cycle |
| res_hit | output | 1 | Match in the indexed set |
| res_miss | output | 1 | No match in any candidate set |
| res_alias | output | 1 | Match only in a non-indexed candidate set |
| res_way | output | 1 | Way of the hit or aliased line |
| res_alias_set | output | 8 | Set index of the aliased line |
| res_writeback | output | 1 | The aliased line is dirty |

## Verification
Lookups are aimed at the indexed set in each way, at a neighbouring candidate set, and at frames that differ from a stored tag by one bit. Together these separate a hit from an alias from a miss, and they show that the compare uses all 20 tag bits and not just the part above the index. Store lookups that hit, miss and alias are each followed by a read that aliases onto the same line, so the reported writeback flag shows whether the dirty flag moved, including after a refill of a dirty line. Lookups issued back to back, and a fill placed in the same cycle as an alias invalidation, check that a later access sees the state left by the earlier one and that the fill takes precedence.

// File: rtl/atl_pkg.sv
// Shared defaults and types for the alias-aware tag lookup.
// Assumes a byte-addressed physical space with 4 KB pages.
package atl_pkg;
    localparam int PA_W_DEF   = 32;  // physical address width
    localparam int PAGE_W_DEF = 12;  // untranslated page offset width
    localparam int IDX_LO_DEF = 6;   // lowest address bit of the set index
    localparam int IDX_W_DEF  = 8;   // set index width
    localparam int WAYS_DEF   = 2;   // associativity

    // Outcome of the second lookup cycle
    typedef enum logic [1:0] {
        OUT_NONE  = 2'd0,
        OUT_HIT   = 2'd1,
        OUT_MISS  = 2'd2,
        OUT_ALIAS = 2'd3
    } outcome_e;
endpackage

// File: rtl/atl_tag_store.sv
// Tag, valid and dirty storage for every line, plus the first-cycle read
// of all candidate sets. The read sees this cycle's updates (fill and
// second-cycle invalidate or dirty marking), so back-to-back lookups
// observe each other. A fill has priority over any other update of the
// same line. Assumes a fill never puts a tag in a set whose other way
// already holds the same valid tag.
module atl_tag_store #(
    parameter int TAG_W = 20,
    parameter int IDX_W = 8,
    parameter int HI_W  = 2,
    parameter int WAYS  = 2,
    localparam int WAY_W = $clog2(WAYS),
    localparam int SETS  = 1 << IDX_W,
    localparam int CANDS = 1 << HI_W,
    localparam int LO_W  = IDX_W - HI_W,
    localparam int LINES = CANDS * WAYS
) (
    input  logic                   clk,
    input  logic                   rst_n,
    // first-cycle read request
    input  logic                   rd_en,
    input  logic [IDX_W-1:0]       rd_vidx,
    // registered candidate contents, line i = cand*WAYS + way
    output logic [LINES*TAG_W-1:0] cand_tag,
    output logic [LINES-1:0]       cand_vld,
    output logic [LINES-1:0]       cand_drt,
    // second-cycle updates
    input  logic                   upd_inv,
    input  logic [IDX_W-1:0]       upd_inv_set,
    input  logic [WAY_W-1:0]       upd_inv_way,
    input  logic                   upd_dirty,
    input  logic [IDX_W-1:0]       upd_dirty_set,
    input  logic [WAY_W-1:0]       upd_dirty_way,
    // fill
    input  logic                   fill_en,
    input  logic [IDX_W-1:0]       fill_set,
    input  logic [WAY_W-1:0]       fill_way,
    input  logic [TAG_W-1:0]       fill_tag
);
    logic [TAG_W-1:0] tag_q [SETS][WAYS];
    logic [WAYS-1:0]  vld_q [SETS];
    logic [WAYS-1:0]  drt_q [SETS];

    // Apply updates to the arrays; later statements win, so fill is last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s] <= '0;
                drt_q[s] <= '0;
            end
        end else begin
            if (upd_inv) begin
                vld_q[upd_inv_set][upd_inv_way] <= 1'b0;
                drt_q[upd_inv_set][upd_inv_way] <= 1'b0;
            end
            if (upd_dirty) begin
                drt_q[upd_dirty_set][upd_dirty_way] <= 1'b1;
            end
            if (fill_en) begin
                tag_q[fill_set][fill_way] <= fill_tag;
                vld_q[fill_set][fill_way] <= 1'b1;
                drt_q[fill_set][fill_way] <= 1'b0;
            end
        end
    end

    genvar gc, gw;
    generate
        for (gc = 0; gc < CANDS; gc++) begin : g_cand
            logic [IDX_W-1:0] set_c;
            assign set_c = {HI_W'(gc), rd_vidx[LO_W-1:0]};
            for (gw = 0; gw < WAYS; gw++) begin : g_way
                localparam int LI = gc * WAYS + gw;
                logic [TAG_W-1:0] nxt_tag;
                logic             nxt_vld;
                logic             nxt_drt;
                logic             hit_inv, hit_drt, hit_fill;

                assign hit_inv  = upd_inv   && upd_inv_set   == set_c && upd_inv_way   == WAY_W'(gw);
                assign hit_drt  = upd_dirty && upd_dirty_set == set_c && upd_dirty_way == WAY_W'(gw);
                assign hit_fill = fill_en   && fill_set      == set_c && fill_way      == WAY_W'(gw);

                // Forward this cycle's update into the value being read.
                always_comb begin
                    nxt_tag = tag_q[set_c][gw];
                    nxt_vld = vld_q[set_c][gw];
                    nxt_drt = drt_q[set_c][gw];
                    if (hit_inv) begin
                        nxt_vld = 1'b0;
                        nxt_drt = 1'b0;
                    end
                    if (hit_drt) nxt_drt = 1'b1;
                    if (hit_fill) begin
                        nxt_tag = fill_tag;
                        nxt_vld = 1'b1;
                        nxt_drt = 1'b0;
                    end
                end

                // Register the candidate line at the end of the first cycle.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        cand_vld[LI] <= 1'b0;
                        cand_drt[LI] <= 1'b0;
                        cand_tag[LI*TAG_W +: TAG_W] <= '0;
                    end else if (rd_en) begin
                        cand_vld[LI] <= nxt_vld;
                        cand_drt[LI] <= nxt_drt;
                        cand_tag[LI*TAG_W +: TAG_W] <= nxt_tag;
                    end
                end
            end
        end
    endgenerate

    // R9
    fill_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> vld_q[$past(fill_set)][$past(fill_way)]
                 && !drt_q[$past(fill_set)][$past(fill_way)]
                 && tag_q[$past(fill_set)][$past(fill_way)] == $past(fill_tag));

    // R7
    alias_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_inv && !(fill_en && fill_set == upd_inv_set && fill_way == upd_inv_way))
        |=> !vld_q[$past(upd_inv_set)][$past(upd_inv_way)]);

    // R8
    dirty_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_dirty && !(fill_en && fill_set == upd_dirty_set && fill_way == upd_dirty_way))
        |=> drt_q[$past(upd_dirty_set)][$past(upd_dirty_way)]);

    // R3 (two ways of one set never hold the same valid tag)
    no_dup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |-> !(vld_q[fill_set][~fill_way] && tag_q[fill_set][~fill_way] == fill_tag));
endmodule

// File: rtl/atl_match.sv
// Second-cycle compare of all candidate lines against the translated frame.
// A match in the candidate named by the virtual index gives a hit; else
// the first match elsewhere (lowest candidate, then lowest way) gives an
// alias. Purely combinational.
module atl_match #(
    parameter int TAG_W = 20,
    parameter int HI_W  = 2,
    parameter int WAYS  = 2,
    localparam int WAY_W = $clog2(WAYS),
    localparam int CANDS = 1 << HI_W,
    localparam int LINES = CANDS * WAYS
) (
    input  logic [LINES*TAG_W-1:0] cand_tag,
    input  logic [LINES-1:0]       cand_vld,
    input  logic [LINES-1:0]       cand_drt,
    input  logic [HI_W-1:0]        idx_hi,
    input  logic [TAG_W-1:0]       frame,
    output logic                   hit,
    output logic [WAY_W-1:0]       hit_way,
    output logic                   alias_fnd,
    output logic [WAY_W-1:0]       alias_way,
    output logic [HI_W-1:0]        alias_cand,
    output logic                   alias_dirty
);
    logic [LINES-1:0] match;

    genvar gl;
    generate
        for (gl = 0; gl < LINES; gl++) begin : g_cmp
            assign match[gl] = cand_vld[gl] && (cand_tag[gl*TAG_W +: TAG_W] == frame);
        end
    endgenerate

    // Pick the hit way inside the indexed candidate.
    always_comb begin
        hit     = 1'b0;
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!hit && match[int'(idx_hi) * WAYS + w]) begin
                hit     = 1'b1;
                hit_way = WAY_W'(w);
            end
        end
    end

    // Pick the first match outside the indexed candidate.
    always_comb begin
        logic found;
        found       = 1'b0;
        alias_way   = '0;
        alias_cand  = '0;
        alias_dirty = 1'b0;
        for (int c = 0; c < CANDS; c++) begin
            for (int w = 0; w < WAYS; w++) begin
                if (!found && HI_W'(c) != idx_hi && match[c * WAYS + w]) begin
                    found       = 1'b1;
                    alias_way   = WAY_W'(w);
                    alias_cand  = HI_W'(c);
                    alias_dirty = cand_drt[c * WAYS + w];
                end
            end
        end
        alias_fnd = found && !hit;
    end
endmodule

// File: rtl/alias_tag_lookup.sv
// Top of the alias-aware virtually indexed tag lookup. Cycle 1 registers
// the request and reads every candidate set; cycle 2 compares against the
// translated frame, presents the outcome, and at the closing edge marks a
// written hit dirty or invalidates an aliased line.
// Assumes xl_frame is valid in the cycle after lk_valid.
module alias_tag_lookup
    import atl_pkg::*;
#(
    parameter int PA_W   = PA_W_DEF,
    parameter int PAGE_W = PAGE_W_DEF,
    parameter int IDX_LO = IDX_LO_DEF,
    parameter int IDX_W  = IDX_W_DEF,
    parameter int WAYS   = WAYS_DEF,
    localparam int TAG_W = PA_W - PAGE_W,
    localparam int HI_W  = IDX_LO + IDX_W - PAGE_W,
    localparam int LO_W  = IDX_W - HI_W,
    localparam int CANDS = 1 << HI_W,
    localparam int LINES = CANDS * WAYS,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [IDX_W-1:0] lk_vidx,
    input  logic             lk_write,
    input  logic [TAG_W-1:0] xl_frame,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_set,
    input  logic [WAY_W-1:0] fill_way,
    input  logic [TAG_W-1:0] fill_tag,
    output logic             res_valid,
    output logic             res_hit,
    output logic             res_miss,
    output logic             res_alias,
    output logic [WAY_W-1:0] res_way,
    output logic [IDX_W-1:0] res_alias_set,
    output logic             res_writeback
);
    logic             s1_vld;
    logic [IDX_W-1:0] s1_vidx;
    logic             s1_wr;

    logic [LINES*TAG_W-1:0] cand_tag;
    logic [LINES-1:0]       cand_vld;
    logic [LINES-1:0]       cand_drt;

    logic             m_hit, m_alias, m_alias_dirty;
    logic [WAY_W-1:0] m_hit_way, m_alias_way;
    logic [HI_W-1:0]  m_alias_cand;
    outcome_e         outcome;

    logic             upd_inv, upd_dirty;
    logic [IDX_W-1:0] alias_set;

    // Hold the request for its second cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld  <= 1'b0;
            s1_vidx <= '0;
            s1_wr   <= 1'b0;
        end else begin
            s1_vld <= lk_valid;
            if (lk_valid) begin
                s1_vidx <= lk_vidx;
                s1_wr   <= lk_write;
            end
        end
    end

    atl_tag_store #(
        .TAG_W(TAG_W), .IDX_W(IDX_W), .HI_W(HI_W), .WAYS(WAYS)
    ) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_en        (lk_valid),
        .rd_vidx      (lk_vidx),
        .cand_tag     (cand_tag),
        .cand_vld     (cand_vld),
        .cand_drt     (cand_drt),
        .upd_inv      (upd_inv),
        .upd_inv_set  (alias_set),
        .upd_inv_way  (m_alias_way),
        .upd_dirty    (upd_dirty),
        .upd_dirty_set(s1_vidx),
        .upd_dirty_way(m_hit_way),
        .fill_en      (fill_en),
        .fill_set     (fill_set),
        .fill_way     (fill_way),
        .fill_tag     (fill_tag)
    );

    atl_match #(
        .TAG_W(TAG_W), .HI_W(HI_W), .WAYS(WAYS)
    ) u_match (
        .cand_tag   (cand_tag),
        .cand_vld   (cand_vld),
        .cand_drt   (cand_drt),
        .idx_hi     (s1_vidx[IDX_W-1 -: HI_W]),
        .frame      (xl_frame),
        .hit        (m_hit),
        .hit_way    (m_hit_way),
        .alias_fnd  (m_alias),
        .alias_way  (m_alias_way),
        .alias_cand (m_alias_cand),
        .alias_dirty(m_alias_dirty)
    );

    assign alias_set = {m_alias_cand, s1_vidx[LO_W-1:0]};

    // Classify the second-cycle result.
    always_comb begin
        if (!s1_vld)      outcome = OUT_NONE;
        else if (m_hit)   outcome = OUT_HIT;
        else if (m_alias) outcome = OUT_ALIAS;
        else              outcome = OUT_MISS;
    end

    assign upd_inv   = (outcome == OUT_ALIAS);
    assign upd_dirty = (outcome == OUT_HIT) && s1_wr;

    assign res_valid     = s1_vld;
    assign res_hit       = (outcome == OUT_HIT);
    assign res_miss      = (outcome == OUT_MISS);
    assign res_alias     = (outcome == OUT_ALIAS);
    assign res_way       = res_alias ? m_alias_way : m_hit_way;
    assign res_alias_set = res_alias ? alias_set : '0;
    assign res_writeback = res_alias && m_alias_dirty;

    // R2
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $countones({res_hit, res_miss, res_alias}) == 1);

    // R2
    quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> !(res_hit || res_miss || res_alias || res_writeback));

    // R2
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(lk_valid)) |-> res_valid);

    // R6
    wb_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_writeback |-> res_alias);

    // R5
    alias_other_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(lk_valid) && res_alias)
        |-> (res_alias_set[IDX_W-1 -: HI_W] != $past(lk_vidx[IDX_W-1 -: HI_W]))
         && (res_alias_set[LO_W-1:0] == $past(lk_vidx[LO_W-1:0])));
endmodule

// File: tb/sim_alias_tag_lookup.sv
// Directed bench: one task per scenario, each checks its own results.
module sim_alias_tag_lookup;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        lk_valid, lk_write;
    logic [7:0]  lk_vidx;
    logic [19:0] xl_frame;
    logic        fill_en, fill_way;
    logic [7:0]  fill_set;
    logic [19:0] fill_tag;
    logic        res_valid, res_hit, res_miss, res_alias, res_way, res_writeback;
    logic [7:0]  res_alias_set;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    localparam int K_MISS = 0, K_HIT = 1, K_ALIAS = 2;

    always #5 clk = ~clk;

    alias_tag_lookup u0 (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vidx(lk_vidx),
        .lk_write(lk_write), .xl_frame(xl_frame), .fill_en(fill_en),
        .fill_set(fill_set), .fill_way(fill_way), .fill_tag(fill_tag),
        .res_valid(res_valid), .res_hit(res_hit), .res_miss(res_miss),
        .res_alias(res_alias), .res_way(res_way), .res_alias_set(res_alias_set),
        .res_writeback(res_writeback)
    );

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Compare the presented result against the expected outcome.
    task automatic chk_res(string req, int kind, int way, int set, int wb);
        int k;
        k = res_hit ? K_HIT : (res_alias ? K_ALIAS : (res_miss ? K_MISS : -1));
        chk(req, "valid", int'(res_valid), 1);
        chk(req, "outcome", k, kind);
        if (kind != K_MISS) chk(req, "way", int'(res_way), way);
        if (kind == K_ALIAS) begin
            chk(req, "alias_set", int'(res_alias_set), set);
            chk(req, "writeback", int'(res_writeback), wb);
        end else begin
            chk(req, "writeback", int'(res_writeback), 0);
        end
    endtask

    task automatic do_fill(logic [7:0] s, logic w, logic [19:0] t);
        @(negedge clk);
        fill_en = 1'b1; fill_set = s; fill_way = w; fill_tag = t;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    task automatic look(string req, logic [7:0] v, logic wr, logic [19:0] f,
                        int kind, int way, int set, int wb);
        @(negedge clk);
        lk_valid = 1'b1; lk_vidx = v; lk_write = wr;
        @(negedge clk);
        lk_valid = 1'b0; lk_write = 1'b0; xl_frame = f;
        #1 chk_res(req, kind, way, set, wb);
    endtask

    // Second lookup starts in the result cycle of the first.
    task automatic look_b2b(string req,
                            logic [7:0] va, logic wa, logic [19:0] fa, int ka, int wya, int sa, int wba,
                            logic [7:0] vb, logic [19:0] fb, int kb, int wyb, int sb, int wbb);
        @(negedge clk);
        lk_valid = 1'b1; lk_vidx = va; lk_write = wa;
        @(negedge clk);
        lk_vidx = vb; lk_write = 1'b0; xl_frame = fa;
        #1 chk_res(req, ka, wya, sa, wba);
        @(negedge clk);
        lk_valid = 1'b0; xl_frame = fb;
        #1 chk_res(req, kb, wyb, sb, wbb);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1", "valid after reset", int'(res_valid), 0);
        look("R1", 8'h00, 1'b0, 20'h00000, K_MISS, 0, 0, 0);
        look("R1", 8'hC5, 1'b0, 20'h3C3C0, K_MISS, 0, 0, 0);
        look("R1", 8'hFF, 1'b0, 20'hFFFFF, K_MISS, 0, 0, 0);
    endtask

    task automatic t_hit();
        do_fill(8'h05, 1'b0, 20'h3C3C0);
        do_fill(8'h05, 1'b1, 20'h3C3C4);
        look("R3", 8'h05, 1'b0, 20'h3C3C0, K_HIT, 0, 0, 0);
        look("R3", 8'h05, 1'b0, 20'h3C3C4, K_HIT, 1, 0, 0);
        @(negedge clk);
        #1 chk("R2", "valid when idle", int'(res_valid), 0);
    endtask

    task automatic t_tag_width();
        look("R4", 8'h05, 1'b0, 20'hBC3C0, K_MISS, 0, 0, 0);
        look("R4", 8'h05, 1'b0, 20'h3C3C1, K_MISS, 0, 0, 0);
    endtask

    task automatic t_alias_clean();
        do_fill(8'h45, 1'b1, 20'h12341);
        look("R5", 8'hC5, 1'b0, 20'h12341, K_ALIAS, 1, 8'h45, 0);
        look("R7", 8'h45, 1'b0, 20'h12341, K_MISS, 0, 0, 0);
    endtask

    task automatic t_dirty();
        do_fill(8'h45, 1'b0, 20'h12341);
        look("R8", 8'h45, 1'b1, 20'h12341, K_HIT, 0, 0, 0);
        look("R6", 8'h85, 1'b0, 20'h12341, K_ALIAS, 0, 8'h45, 1);
    endtask

    task automatic t_write_miss();
        do_fill(8'h46, 1'b0, 20'h55551);
        look("R12", 8'h46, 1'b1, 20'h0AAA1, K_MISS, 0, 0, 0);
        do_fill(8'h47, 1'b0, 20'h66661);
        look("R12", 8'h07, 1'b1, 20'h66661, K_ALIAS, 0, 8'h47, 0);
        look("R12", 8'h06, 1'b0, 20'h55551, K_ALIAS, 0, 8'h46, 0);
    endtask

    task automatic t_refill_clean();
        do_fill(8'h4B, 1'b1, 20'h0F0F1);
        look("R9", 8'h4B, 1'b1, 20'h0F0F1, K_HIT, 1, 0, 0);
        do_fill(8'h4B, 1'b1, 20'h0F0F1);
        look("R9", 8'h0B, 1'b0, 20'h0F0F1, K_ALIAS, 1, 8'h4B, 0);
    endtask

    task automatic t_b2b();
        do_fill(8'h48, 1'b0, 20'h77771);
        look_b2b("R10", 8'h08, 1'b0, 20'h77771, K_ALIAS, 0, 8'h48, 0,
                        8'h08, 20'h77771, K_MISS, 0, 0, 0);
        do_fill(8'h49, 1'b0, 20'h88881);
        look_b2b("R10", 8'h49, 1'b1, 20'h88881, K_HIT, 0, 0, 0,
                        8'h09, 20'h88881, K_ALIAS, 0, 8'h49, 1);
    endtask

    task automatic t_fill_priority();
        do_fill(8'h4A, 1'b0, 20'h99991);
        @(negedge clk);
        lk_valid = 1'b1; lk_vidx = 8'h0A; lk_write = 1'b0;
        @(negedge clk);
        lk_valid = 1'b0; xl_frame = 20'h99991;
        fill_en = 1'b1; fill_set = 8'h4A; fill_way = 1'b0; fill_tag = 20'hABCD1;
        #1 chk_res("R11", K_ALIAS, 0, 8'h4A, 0);
        @(negedge clk);
        fill_en = 1'b0;
        look("R11", 8'h4A, 1'b0, 20'hABCD1, K_HIT, 0, 0, 0);
        look("R11", 8'h4A, 1'b0, 20'h99991, K_MISS, 0, 0, 0);
    endtask

    // Main sequence.
    initial begin
        rst_n = 1'b0; lk_valid = 1'b0; lk_write = 1'b0; lk_vidx = '0;
        xl_frame = '0; fill_en = 1'b0; fill_set = '0; fill_way = 1'b0; fill_tag = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_hit();
        t_tag_width();
        t_alias_clean();
        t_dirty();
        t_write_miss();
        t_refill_clean();
        t_b2b();
        t_fill_priority();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule